// File: doc/BRIEF.md
# Programmable Clock Divider Tree

This block derives a family of clocks from one of two reference clocks. A mode pin picks the reference: either an external clock input or the output of an on-chip oscillator. The selected reference appears undivided on an auxiliary output. It also feeds an oscillator divider and a pre-divider. The pre-divider output goes to an external frequency multiplier. The multiplier's output comes back on a plain clock input. A control bit then decides whether three system dividers run from that multiplier output or straight from the reference.

Each divider has a 5-bit ratio and an enable bit. It produces a 50% duty clock for odd and even ratios alike, and a disabled divider holds its output low. A ratio change waits for the divider's next rising output edge, so the period in progress always completes. While reset is held, every output carries the reference divided by 8.

All logic runs on one fast sampling clock. The references and the multiplier output are synchronised and edge-detected, so each must be slower than half the sampling clock. Configuration goes through a small register write port with a combinational read port.

Top module: `clk_div_tree`

## Requirements
- R1: `ref_sel`=1 selects `ref_ext_clk` and `ref_sel`=0 selects `ref_osc_clk`. Outside reset, `aux_clk` is the selected reference with no division.
- R2: A divider with ratio field r divides its source by r+1 (÷1 to ÷32). High and low phases each last r+1 source half-periods, giving 50% duty for odd ratios too.
- R3: Control register (address 0) bit 0 picks the system-divider source. At 1, the three system dividers count `mult_clk`; at 0, they count the selected reference. The pre-divider and the oscillator divider always count the reference.
- R4: Every divider register holds its enable at bit 15 and its ratio at bits 4:0. When the enable is 0, that divider's output stays low. Setting it to 1 again restarts the divider.
- R5: While `rst` is high, `aux_clk`, `osc_div_clk`, `sys_clk[2:0]` and `mult_ref_clk` all toggle every 8 reference half-periods.
- R6: Register values after reset, read as 16-bit words:
  - address 0 reads 0x0000;
  - address 1 reads 0x0007;
  - addresses 2 and 3 read 0x8000;
  - addresses 4 and 5 read 0x8001;
  - address 6 reads 0x8007.
- R7: The register map is: 0 control, 1 multiplier factor, 2 pre-divider (drives `mult_ref_clk`), 3/4/5 system dividers for `sys_clk[0]`/`sys_clk[1]`/`sys_clk[2]`, 6 oscillator divider. Bits outside the defined fields read 0, and writes to them have no effect. Address 7 reads 0.
- R8: A new ratio written during an output period takes effect at the divider's next rising output edge. The current high and low phases finish at the old ratio.
- R9: `mult_factor` equals bits 4:0 of register 1 and changes only after a write.
- R10: A divider's output changes only after an edge of its source, after a reset, or after its enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| ref_ext_clk | input | 1 | External reference clock |
| ref_osc_clk | input | 1 | On-chip oscillator reference clock |
| ref_sel | input | 1 | Reference select: 1 external, 0 oscillator |
| mult_clk | input | 1 | Output of the external frequency multiplier |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| aux_clk | output | 1 | Undivided selected reference |
| osc_div_clk | output | 1 | Oscillator divider output |
| sys_clk | output | 3 | System divider outputs |
| mult_ref_clk | output | 1 | Pre-divider output, feeding the multiplier |
| mult_factor | output | 5 | Multiplier factor field for the multiplier |

## Verification
The bound checker checks several rules on every cycle:
- divider outputs move only after a source edge, a reset or a disable;
- a cleared enable forces the output low;
- the outputs agree with one another during reset;
- reserved read bits stay zero;
- the multiplier factor is stable between writes.

Other behaviour needs a measured waveform and is shown only by the bench's scenarios. This covers the actual divide ratios and duty of each divider, the source routing in bypass and multiplied modes, the divide-by-8 reset clock, and a ratio change landing only at the next rising edge.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

    localparam int RATIO_W   = 5;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 3;
    localparam int EN_BIT    = 15;
    localparam int NUM_SYS   = 3;
    localparam int NUM_DIV   = NUM_SYS + 2;
    localparam int PRE_IDX   = 0;
    localparam int OSC_IDX   = NUM_SYS + 1;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_MULT = 1;
    localparam int ADDR_DIV0 = 2;

    localparam logic [RATIO_W-1:0] MULT_RESET = RATIO_W'(7);
    localparam logic [RATIO_W-1:0] OSC_RESET  = RATIO_W'(7);

    typedef struct packed {
        logic               en;
        logic [RATIO_W-1:0] ratio;
    } div_cfg_t;

    // Reset value of the divider at array index idx
    function automatic div_cfg_t div_reset(int idx);
        div_cfg_t c;
        c.en = 1'b1;
        if (idx == OSC_IDX)
            c.ratio = OSC_RESET;
        else if (idx >= 2)
            c.ratio = RATIO_W'(1);
        else
            c.ratio = '0;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] div_word(div_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT] = c.en;
        w[RATIO_W-1:0] = c.ratio;
        return w;
    endfunction

endpackage

// File: rtl/ckd_edge_sense.sv
module ckd_edge_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        sync_q <= {sync_q[STAGES-2:0], async_in};
        prev_q <= sync_q[STAGES-1];
    end

    assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/ckd_divider.sv
module ckd_divider
    import ckd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               src_edge,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               div_o
);
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] ratio_act_q;
    logic               lvl_q;

    // Count source edges (both polarities); toggle after ratio+1 of them.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q       <= '0;
            lvl_q       <= 1'b0;
            ratio_act_q <= ratio;
        end else if (src_edge) begin
            if (cnt_q == ratio_act_q) begin
                cnt_q <= '0;
                lvl_q <= !lvl_q;
                if (!lvl_q)
                    ratio_act_q <= ratio;   // new period starts: adopt ratio
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign div_o = lvl_q;
endmodule

// File: rtl/ckd_regs.sv
module ckd_regs
    import ckd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic                        chain_en,
    output logic [RATIO_W-1:0]          mult_q,
    output div_cfg_t [NUM_DIV-1:0]      cfg
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[EN_BIT-1:RATIO_W], wdata[DATA_W-1:EN_BIT+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_en <= 1'b0;
            mult_q   <= MULT_RESET;
            for (int i = 0; i < NUM_DIV; i++)
                cfg[i] <= div_reset(i);
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADDR_CTRL))
                chain_en <= wdata[0];
            if (addr == ADDR_W'(ADDR_MULT))
                mult_q <= wdata[RATIO_W-1:0];
            for (int i = 0; i < NUM_DIV; i++) begin
                if (addr == ADDR_W'(ADDR_DIV0 + i)) begin
                    cfg[i].en    <= wdata[EN_BIT];
                    cfg[i].ratio <= wdata[RATIO_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL))
            rdata[0] = chain_en;
        if (addr == ADDR_W'(ADDR_MULT))
            rdata[RATIO_W-1:0] = mult_q;
        for (int i = 0; i < NUM_DIV; i++)
            if (addr == ADDR_W'(ADDR_DIV0 + i))
                rdata = div_word(cfg[i]);
    end
endmodule

// File: rtl/clk_div_tree.sv
module clk_div_tree
    import ckd_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int RST_DIV_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_ext_clk,
    input  logic               ref_osc_clk,
    input  logic               ref_sel,
    input  logic               mult_clk,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               aux_clk,
    output logic               osc_div_clk,
    output logic [NUM_SYS-1:0] sys_clk,
    output logic               mult_ref_clk,
    output logic [RATIO_W-1:0] mult_factor
);
    localparam int RCNT_W = RST_DIV_LOG2 + 1;

    logic                   ref_raw;
    logic                   ref_edge;
    logic                   mult_edge;
    logic                   sys_src_edge;
    logic                   chain_en;
    logic [RCNT_W-1:0]      rcnt_q;
    logic                   rst_clk;
    div_cfg_t [NUM_DIV-1:0] div_cfg;
    logic [NUM_DIV-1:0]     div_raw;
    logic [NUM_DIV-1:0]     div_src_edge;
    logic [NUM_DIV-1:0]     div_en;

    assign ref_raw = ref_sel ? ref_ext_clk : ref_osc_clk;

    ckd_edge_sense #(.STAGES(SYNC_STAGES)) u_ref_sense (
        .clk(clk), .async_in(ref_raw), .edge_o(ref_edge)
    );

    ckd_edge_sense #(.STAGES(SYNC_STAGES)) u_mult_sense (
        .clk(clk), .async_in(mult_clk), .edge_o(mult_edge)
    );

    ckd_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .chain_en(chain_en), .mult_q(mult_factor), .cfg(div_cfg)
    );

    // Free-running reference edge counter: the reset-time clock
    always_ff @(posedge clk) begin
        if (ref_edge)
            rcnt_q <= rcnt_q + 1'b1;
    end
    assign rst_clk = rcnt_q[RCNT_W-1];

    assign sys_src_edge = chain_en ? mult_edge : ref_edge;

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        if (i >= 1 && i <= NUM_SYS) begin : g_sys_src
            assign div_src_edge[i] = sys_src_edge;
        end else begin : g_ref_src
            assign div_src_edge[i] = ref_edge;
        end
        assign div_en[i] = div_cfg[i].en;

        ckd_divider u_div (
            .clk(clk), .rst(rst), .src_edge(div_src_edge[i]),
            .en(div_cfg[i].en), .ratio(div_cfg[i].ratio), .div_o(div_raw[i])
        );
    end

    for (genvar k = 0; k < NUM_SYS; k++) begin : g_sys_out
        assign sys_clk[k] = rst ? rst_clk : div_raw[k+1];
    end

    assign mult_ref_clk = rst ? rst_clk : div_raw[PRE_IDX];
    assign osc_div_clk  = rst ? rst_clk : div_raw[OSC_IDX];
    assign aux_clk      = rst ? rst_clk : ref_raw;
endmodule

// File: rtl/ckd_checker.sv
module ckd_checker
    import ckd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  rdata,
    input logic [RATIO_W-1:0] mult_factor,
    input logic [NUM_SYS-1:0] sys_clk,
    input logic               osc_div_clk,
    input logic               mult_ref_clk,
    input logic [NUM_DIV-1:0] div_raw,
    input logic [NUM_DIV-1:0] div_src_edge,
    input logic [NUM_DIV-1:0] div_en
);
    // R5
    rst_outputs_agree_chk: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (sys_clk == {NUM_SYS{osc_div_clk}} && mult_ref_clk == osc_div_clk));

    // R7
    div_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr >= ADDR_W'(ADDR_DIV0)) |-> (rdata[EN_BIT-1:RATIO_W] == '0));

    // R7
    ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(ADDR_CTRL)) |-> (rdata[DATA_W-1:1] == '0));

    // R9
    mult_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(mult_factor));

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_chk
        // R4
        disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(div_en[i])) |-> !div_raw[i]);

        // R10
        edge_only_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && div_raw[i] != $past(div_raw[i]))
                |-> ($past(div_src_edge[i]) || !$past(div_en[i])));
    end
endmodule

bind clk_div_tree ckd_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .rdata(rdata),
    .mult_factor(mult_factor), .sys_clk(sys_clk), .osc_div_clk(osc_div_clk),
    .mult_ref_clk(mult_ref_clk), .div_raw(div_raw), .div_src_edge(div_src_edge),
    .div_en(div_en)
);

// File: tb/clk_div_tree_test.sv
module clk_div_tree_test;
    import ckd_pkg::*;

    localparam int H_EXT = 3;   // reference half-periods in clk cycles
    localparam int H_OSC = 5;
    localparam int H_MUL = 2;
    localparam int LIM   = 3000;

    logic clk = 1'b0;
    always #10 clk = ~clk;      // 50 MHz

    logic        rst = 1'b1, ref_ext = 1'b0, ref_osc = 1'b0, ref_sel = 1'b1;
    logic        mult_clk = 1'b0, wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        aux_clk, osc_div_clk, mult_ref_clk;
    logic [2:0]  sys_clk;
    logic [4:0]  mult_factor;
    logic [5:0]  obs;

    int checks = 0, errors = 0;
    bit done = 0;

    clk_div_tree uut (
        .clk(clk), .rst(rst), .ref_ext_clk(ref_ext), .ref_osc_clk(ref_osc),
        .ref_sel(ref_sel), .mult_clk(mult_clk), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .aux_clk(aux_clk), .osc_div_clk(osc_div_clk),
        .sys_clk(sys_clk), .mult_ref_clk(mult_ref_clk), .mult_factor(mult_factor)
    );

    // obs index: 0 aux, 1 osc, 2..4 sys, 5 pre-divider
    assign obs = {mult_ref_clk, sys_clk, osc_div_clk, aux_clk};

    initial forever begin repeat (H_EXT) @(negedge clk); ref_ext = ~ref_ext; end
    initial forever begin repeat (H_OSC) @(negedge clk); ref_osc = ~ref_osc; end
    initial forever begin repeat (H_MUL) @(negedge clk); mult_clk = ~mult_clk; end

    typedef struct packed {
        logic       sel;
        logic       chain;
        logic [2:0] a;
        logic [4:0] ratio;
        logic [2:0] idx;
        logic [7:0] half;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 3'd3, 5'd0,  3'd2, 8'd3,  4'd2},   // R2 divide by 1
        '{1'b1, 1'b0, 3'd4, 5'd2,  3'd3, 8'd9,  4'd2},   // R2 odd ratio
        '{1'b1, 1'b0, 3'd5, 5'd31, 3'd4, 8'd96, 4'd2},   // R2 divide by 32
        '{1'b0, 1'b0, 3'd3, 5'd4,  3'd2, 8'd25, 4'd1},   // R1 oscillator ref
        '{1'b1, 1'b1, 3'd3, 5'd1,  3'd2, 8'd4,  4'd3},   // R3 multiplier source
        '{1'b1, 1'b1, 3'd5, 5'd6,  3'd4, 8'd14, 4'd3},   // R3 odd via multiplier
        '{1'b0, 1'b1, 3'd4, 5'd2,  3'd3, 8'd6,  4'd3},   // R3 ref_sel irrelevant
        '{1'b1, 1'b1, 3'd2, 5'd3,  3'd5, 8'd12, 4'd3},   // R3 pre-divider on ref
        '{1'b0, 1'b0, 3'd6, 5'd2,  3'd1, 8'd15, 4'd3},   // R3 oscillator divider
        '{1'b0, 1'b1, 3'd6, 5'd1,  3'd1, 8'd10, 4'd3},   // R3 osc divider ignores mode
        '{1'b0, 1'b0, 3'd7, 5'd0,  3'd0, 8'd5,  4'd1},   // R1 aux from oscillator
        '{1'b1, 1'b0, 3'd7, 5'd0,  3'd0, 8'd3,  4'd1}    // R1 aux from external
    };

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk); addr = a;
        @(posedge clk); #1; v = rdata;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(input int idx, output bit ok);
        int g = 0;
        logic p = obs[idx];
        ok = 0;
        while (g < LIM && !ok) begin
            step(); g++;
            if (!p && obs[idx]) ok = 1;
            p = obs[idx];
        end
    endtask

    // Skip one rise to settle, then measure one high and one low phase
    task automatic measure(input int idx, output int hi, output int lo);
        bit ok;
        int g;
        hi = -1; lo = -1;
        wait_rise(idx, ok);
        if (ok) wait_rise(idx, ok);
        if (ok) begin
            hi = 0; lo = 0; g = 0;
            while (obs[idx] && g < LIM) begin hi++; g++; step(); end
            while (!obs[idx] && g < LIM) begin lo++; g++; step(); end
        end
    endtask

    task automatic chk_half(input int idx, input int exp, input string req);
        int hi, lo;
        measure(idx, hi, lo);
        chk(hi == exp && lo == exp, req, hi * 1000 + lo, exp * 1000 + exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        int hi, lo, hi2, cnt_hi;

        // R5: all outputs at ref/8 while reset is held (external ref)
        repeat (4) step();
        for (int i = 0; i < 6; i++) chk_half(i, 8 * H_EXT, "R5");
        @(negedge clk); rst = 1'b0;
        step();

        // R6: reset values
        rd(3'd0, v); chk(v == 16'h0000, "R6", v, 16'h0000);
        rd(3'd1, v); chk(v == 16'h0007, "R6", v, 16'h0007);
        rd(3'd2, v); chk(v == 16'h8000, "R6", v, 16'h8000);
        rd(3'd3, v); chk(v == 16'h8000, "R6", v, 16'h8000);
        rd(3'd4, v); chk(v == 16'h8001, "R6", v, 16'h8001);
        rd(3'd5, v); chk(v == 16'h8001, "R6", v, 16'h8001);
        rd(3'd6, v); chk(v == 16'h8007, "R6", v, 16'h8007);
        chk(mult_factor == 5'd7, "R9", mult_factor, 7);
        chk_half(3, 2 * H_EXT, "R6");
        chk_half(1, 8 * H_EXT, "R6");

        // Table of configurations
        for (int n = 0; n < NV; n++) begin
            ref_sel = VECS[n].sel;
            wr(3'd0, {15'd0, VECS[n].chain});
            wr(VECS[n].a, {1'b1, 10'd0, VECS[n].ratio});
            chk_half(int'(VECS[n].idx), int'(VECS[n].half),
                     $sformatf("R%0d vec%0d", VECS[n].req, n));
        end

        // R4: disabled divider stays low, then restarts
        ref_sel = 1'b1;
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0002);
        step(); step();
        cnt_hi = 0;
        for (int c = 0; c < 300; c++) begin if (obs[3]) cnt_hi++; step(); end
        chk(cnt_hi == 0, "R4", cnt_hi, 0);
        wr(3'd4, 16'h8002);
        chk_half(3, 3 * H_EXT, "R4");

        // R8: ratio change mid-period completes the current period first
        wr(3'd5, 16'h801F);
        measure(4, hi, lo);
        wait_rise(4, done);
        done = 0;
        hi = 0; lo = 0; hi2 = 0;
        while (obs[4] && hi < LIM) begin
            hi++;
            if (hi == 10) wr(3'd5, 16'h8000); else step();
        end
        while (!obs[4] && lo < LIM) begin lo++; step(); end
        while (obs[4] && hi2 < LIM) begin hi2++; step(); end
        chk(hi == 32 * H_EXT, "R8 old high", hi, 32 * H_EXT);
        chk(lo == 32 * H_EXT, "R8 old low", lo, 32 * H_EXT);
        chk(hi2 == H_EXT, "R8 new high", hi2, H_EXT);

        // R7 / R9: reserved bits and unmapped address
        wr(3'd0, 16'hFFFF); rd(3'd0, v); chk(v == 16'h0001, "R7", v, 16'h0001);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'hFFFF); rd(3'd1, v); chk(v == 16'h001F, "R7", v, 16'h001F);
        chk(mult_factor == 5'd31, "R9", mult_factor, 31);
        wr(3'd2, 16'h7FE3); rd(3'd2, v); chk(v == 16'h0003, "R7", v, 16'h0003);
        wr(3'd7, 16'hFFFF); rd(3'd7, v); chk(v == 16'h0000, "R7", v, 16'h0000);
        rd(3'd4, v); chk(v == 16'h8002, "R7 no alias", v, 16'h8002);

        finish_run();
    end
endmodule